// File: doc/BRIEF.md
# Sector Erase Queue with Inactivity Window

This block sits behind a flash command decoder. When the decoder reports a completed sector erase command, the block opens an inactivity window and records the addressed sector in an 8-bit mask. Each further sector erase command that arrives while the window is open adds its sector to the mask and restarts the window timer. Any other command during the window drops the whole request, and the block returns to read mode.

When the window runs out with no new command, the block issues a one-cycle start strobe that carries the final mask. It then locks. While it is locked, every command is ignored until the external erase engine has raised its busy signal and dropped it again. The window length is given in microseconds and converted to clock cycles from the clock frequency parameter.

Two status outputs show where the block is. `window_open` is high while more sectors can still be added. `window_closed` is high from the start strobe until the erase has finished.

Top module: `sector_erase_queue`

## Requirements
- R1: During and right after reset, `window_open`, `window_closed` and `erase_start` are 0 and `erase_mask` is all zeros.
- R2: In read mode, a sector erase command (`cmd_valid`=1, `cmd_sector_erase`=1) opens the window on the next cycle. `erase_mask` then holds only bit `cmd_sector`, where `cmd_sector` is address bits 16:14 and bit n stands for sector n.
- R3: A sector erase command inside the window sets bit `cmd_sector` of the mask and keeps all bits already set. Repeating a sector that is already queued leaves the mask unchanged.
- R4: Every sector erase command accepted inside the window restarts the timer. `erase_start` rises exactly WIN_CYCLES clock edges after the edge that accepted the last such command, where WIN_CYCLES = CLK_MHZ × WINDOW_US. A command on the expiry edge itself wins and restarts the window.
- R5: A command with `cmd_sector_erase`=0 inside the window clears the mask and returns to read mode on the next cycle, and no start strobe follows.
- R6: On expiry, `erase_start` is high for exactly one cycle, together with the non-zero final mask.
- R7: `window_open` is 1 only while the window runs. `window_closed` is 1 from the start strobe until `erase_busy` has been seen high and then low. The two are never both 1.
- R8: While `window_closed` is 1, commands have no effect: the mask stays the same, no window opens and no new start strobe appears.
- R9: In read mode, a command with `cmd_sector_erase`=0 has no effect: the outputs stay at their reset values.
- R10: When `erase_busy` falls after the erase began, the block returns to read mode with the mask cleared, and it accepts a new sector erase request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command write |
| cmd_sector_erase | input | 1 | 1: the command is a sector erase; 0: any other command |
| cmd_sector | input | SECTOR_BITS | Sector index (address bits 16:14) of the command |
| erase_busy | input | 1 | High while the external erase engine is working |
| window_open | output | 1 | High while more sectors can be queued |
| window_closed | output | 1 | High from erase start until the erase has finished |
| erase_start | output | 1 | One-cycle strobe that commits the erase |
| erase_mask | output | 2**SECTOR_BITS | Queued sectors, bit n for sector n |

## Verification
A behavioural model in the bench predicts all four outputs on every clock. The model is driven with these command patterns:
- A single sector left to expire.
- Several different sectors with gaps shorter than the window.
- A repeated sector.
- A command placed exactly on the expiry edge, which separates restart from expiry.
- A foreign command inside the window, which separates abort from accumulation.
- Commands placed both before and during the busy phase, which show that the lock holds.
- A fresh request after busy falls.

// File: rtl/seq_pkg.sv
// Package: shared control state encoding for the sector erase queue.
// Assumes: nothing beyond standard SystemVerilog.
package seq_pkg;
    typedef enum logic [1:0] {
        ST_READ    = 2'd0,  // no request pending
        ST_WINDOW  = 2'd1,  // collecting sectors, timer running
        ST_STARTED = 2'd2,  // start issued, waiting for busy to rise
        ST_ERASING = 2'd3   // erase engine busy
    } seq_state_t;
endpackage

// File: rtl/seq_window_timer.sv
// Module: inactivity counter for the sector erase window.
// Counts cycles while run is high and returns to zero on restart. expire is
// high in the cycle whose edge completes WIN_CYCLES counted edges with no
// restart. Assumes the controller stops run once expire has been taken.
module seq_window_timer #(
    parameter int WIN_CYCLES = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expire
);
    localparam int CW = $clog2(WIN_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Count edges since the last restart.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (run)     cnt <= cnt + 1'b1;
    end

    // Flag expiry on the final counted edge.
    always_comb expire = run && !restart && (cnt == CW'(WIN_CYCLES - 1));
endmodule

// File: rtl/seq_mask_reg.sv
// Module: sector mask register.
// load replaces the mask with one sector, add ORs one sector in, and clear
// empties it. load and add take priority over clear.
// Assumes: at most one of load/add is high in a cycle.
module seq_mask_reg #(
    parameter int SECTOR_BITS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic                        add,
    input  logic                        clear,
    input  logic [SECTOR_BITS-1:0]      sector,
    output logic [(1<<SECTOR_BITS)-1:0] mask
);
    localparam int NSEC = 1 << SECTOR_BITS;

    logic [NSEC-1:0] onehot;

    // Decode the sector index to a one-hot bit.
    always_comb begin
        onehot = '0;
        onehot[sector] = 1'b1;
    end

    // Update the queued sector set.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask <= '0;
        else if (load)  mask <= onehot;
        else if (add)   mask <= mask | onehot;
        else if (clear) mask <= '0;
    end
endmodule

// File: rtl/seq_ctrl.sv
// Module: control sequencer for the sector erase queue.
// Opens the window on a sector erase command, extends it on further sector
// erase commands, aborts on any other command, fires start on expiry and
// stays locked until erase_busy has risen and fallen.
// Assumes: cmd_valid is a one-cycle strobe per decoded command.
module seq_ctrl
    import seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_sector_erase,
    input  logic erase_busy,
    input  logic expire,
    output logic tmr_run,
    output logic tmr_restart,
    output logic mask_load,
    output logic mask_add,
    output logic mask_clear,
    output logic start_q,
    output logic open_o,
    output logic closed_o
);
    seq_state_t st, nxt;
    logic       fire;

    // Next state and datapath controls.
    always_comb begin
        nxt         = st;
        tmr_run     = 1'b0;
        tmr_restart = 1'b0;
        mask_load   = 1'b0;
        mask_add    = 1'b0;
        mask_clear  = 1'b0;
        fire        = 1'b0;
        case (st)
            ST_READ: begin
                if (cmd_valid && cmd_sector_erase) begin
                    nxt         = ST_WINDOW;
                    mask_load   = 1'b1;
                    tmr_restart = 1'b1;
                end
            end
            ST_WINDOW: begin
                tmr_run = 1'b1;
                if (cmd_valid) begin
                    if (cmd_sector_erase) begin
                        mask_add    = 1'b1;
                        tmr_restart = 1'b1;
                    end else begin
                        mask_clear = 1'b1;
                        nxt        = ST_READ;
                    end
                end else if (expire) begin
                    fire = 1'b1;
                    nxt  = ST_STARTED;
                end
            end
            ST_STARTED: begin
                if (erase_busy) nxt = ST_ERASING;
            end
            default: begin
                if (!erase_busy) begin
                    nxt        = ST_READ;
                    mask_clear = 1'b1;
                end
            end
        endcase
    end

    // State and start strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_READ;
            start_q <= 1'b0;
        end else begin
            st      <= nxt;
            start_q <= fire;
        end
    end

    // Status decode.
    always_comb begin
        open_o   = (st == ST_WINDOW);
        closed_o = (st == ST_STARTED) || (st == ST_ERASING);
    end
endmodule

// File: rtl/sector_erase_queue.sv
// Module: sector erase queue with an inactivity window (top).
// Collects sector erase requests into a mask, commits them after WINDOW_US
// microseconds with no new sector command, and locks until the erase engine
// finishes. Assumes an upstream decoder delivers whole command sequences.
module sector_erase_queue #(
    parameter int CLK_MHZ     = 50,
    parameter int WINDOW_US   = 80,
    parameter int SECTOR_BITS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  logic                        cmd_sector_erase,
    input  logic [SECTOR_BITS-1:0]      cmd_sector,
    input  logic                        erase_busy,
    output logic                        window_open,
    output logic                        window_closed,
    output logic                        erase_start,
    output logic [(1<<SECTOR_BITS)-1:0] erase_mask
);
    localparam int WIN_CYCLES = CLK_MHZ * WINDOW_US;

    logic tmr_run, tmr_restart, expire;
    logic mask_load, mask_add, mask_clear;

    seq_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .restart(tmr_restart),
        .expire(expire)
    );

    seq_mask_reg #(.SECTOR_BITS(SECTOR_BITS)) u_mask (
        .clk(clk), .rst_n(rst_n), .load(mask_load), .add(mask_add),
        .clear(mask_clear), .sector(cmd_sector), .mask(erase_mask)
    );

    seq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_sector_erase(cmd_sector_erase), .erase_busy(erase_busy),
        .expire(expire), .tmr_run(tmr_run), .tmr_restart(tmr_restart),
        .mask_load(mask_load), .mask_add(mask_add), .mask_clear(mask_clear),
        .start_q(erase_start), .open_o(window_open), .closed_o(window_closed)
    );

    // Start is a single-cycle strobe.
    assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);

    // Start carries a non-empty mask and follows an open window.
    assert_start_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> (erase_mask != '0) && $past(window_open));

    // Open and closed status are exclusive.
    assert_status_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(window_open && window_closed));

    // A foreign command inside the window aborts and empties the queue.
    assert_abort_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (window_open && cmd_valid && !cmd_sector_erase)
        |=> (!window_open && !window_closed && erase_mask == '0));

    // A sector command inside the window only adds bits.
    assert_mask_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (window_open && cmd_valid && cmd_sector_erase)
        |=> (window_open && ((erase_mask & $past(erase_mask)) == $past(erase_mask))));

    // While locked, the mask does not move.
    assert_locked_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (window_closed && $past(window_closed)) |-> $stable(erase_mask));
endmodule

// File: tb/sim_sector_erase_queue.sv
module sim_sector_erase_queue;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 1;
    localparam int WINDOW_US  = 10;
    localparam int WIN        = CLK_MHZ * WINDOW_US;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_sector_erase = 1'b0;
    logic [2:0] cmd_sector = 3'd0;
    logic       erase_busy = 1'b0;
    logic       window_open, window_closed, erase_start;
    logic [7:0] erase_mask;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string tag = "R1";

    // Behavioural reference: 0 read, 1 window, 2 started, 3 erasing.
    int m_st = 0;
    int m_mask = 0;
    int m_age = 0;
    bit m_start = 1'b0;

    sector_erase_queue #(.CLK_MHZ(CLK_MHZ), .WINDOW_US(WINDOW_US), .SECTOR_BITS(3)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_sector_erase(cmd_sector_erase), .cmd_sector(cmd_sector),
        .erase_busy(erase_busy), .window_open(window_open),
        .window_closed(window_closed), .erase_start(erase_start),
        .erase_mask(erase_mask)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model update on each edge.
    always @(posedge clk) begin
        cycles++;
        m_start = 1'b0;
        if (!rst_n) begin
            m_st = 0; m_mask = 0; m_age = 0;
        end else if (m_st == 0) begin
            if (cmd_valid && cmd_sector_erase) begin
                m_st = 1; m_mask = 1 << cmd_sector; m_age = 0;
            end
        end else if (m_st == 1) begin
            m_age++;
            if (cmd_valid && cmd_sector_erase) begin
                m_mask = m_mask | (1 << cmd_sector); m_age = 0;
            end else if (cmd_valid) begin
                m_st = 0; m_mask = 0;
            end else if (m_age >= WIN) begin
                m_st = 2; m_start = 1'b1;
            end
        end else if (m_st == 2) begin
            if (erase_busy) m_st = 3;
        end else begin
            if (!erase_busy) begin
                m_st = 0; m_mask = 0;
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp_v, cycles);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        chk("window_open", int'(window_open), (m_st == 1) ? 1 : 0);
        chk("window_closed", int'(window_closed), (m_st >= 2) ? 1 : 0);
        chk("erase_start", int'(erase_start), int'(m_start));
        chk("erase_mask", int'(erase_mask), m_mask);
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input bit se, input int sec);
        cmd_valid = 1'b1;
        cmd_sector_erase = se;
        cmd_sector = 3'(sec);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_sector_erase = 1'b0;
    endtask

    task automatic busy_cycle(input int delay, input int len);
        idle(delay);
        erase_busy = 1'b1;
        idle(len);
        erase_busy = 1'b0;
        idle(2);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        tag = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R9: foreign command in read mode has no effect
        tag = "R9";
        cmd(1'b0, 4);
        idle(3);
        // R2/R6: single sector, let it expire
        tag = "R2";
        cmd(1'b1, 5);
        tag = "R6";
        idle(WIN + 1);
        // R7/R8: commands ignored while waiting for busy and while busy
        tag = "R8";
        cmd(1'b1, 1);
        cmd(1'b0, 0);
        tag = "R7";
        busy_cycle(2, 4);
        // R3/R4: several sectors with gaps, including a duplicate
        tag = "R3";
        cmd(1'b1, 0);
        idle(WIN - 3);
        cmd(1'b1, 7);
        idle(4);
        cmd(1'b1, 7);
        idle(2);
        cmd(1'b1, 2);
        // R4: command exactly on the expiry edge restarts the window
        tag = "R4";
        idle(WIN - 1);
        cmd(1'b1, 3);
        idle(WIN + 1);
        tag = "R8";
        erase_busy = 1'b1;
        cmd(1'b1, 6);
        idle(2);
        erase_busy = 1'b0;
        idle(2);
        // R5: foreign command aborts the window, no start follows
        tag = "R5";
        cmd(1'b1, 4);
        idle(3);
        cmd(1'b1, 1);
        cmd(1'b0, 0);
        idle(WIN + 3);
        // R10: fresh request after a completed erase is accepted
        tag = "R10";
        cmd(1'b1, 6);
        idle(WIN + 1);
        busy_cycle(1, 3);
        cmd(1'b1, 1);
        idle(WIN + 2);
        busy_cycle(0, 2);
        // R1: reset in the middle of a window
        tag = "R1";
        cmd(1'b1, 2);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule